// File: doc/BRIEF.md
# Video Page Shadow Snooper

This block sits beside a retro 8-bit host bus and listens to every bus cycle. Each cycle reaches it as one captured word: a 16-bit address, a data field, a read/not-write flag, and the card's slot-ROM select. The block holds no copy of the shadow RAMs. It produces their write ports instead. When a host write lands in one of the two video windows, the block issues a registered write into one of two shadow banks. A bank-steering flag that arrives with the same word picks the bank, and the address is kept as it came from the bus. A display engine reads those banks later to draw the video pages.

While the slot-ROM select is active, host writes also fill a 32-byte configuration mailbox indexed by the low address bits. A write whose low address byte is all ones raises a single-cycle completion pulse, so firmware knows the mailbox is complete. Firmware reads the mailbox through a plain combinational read port.

The captured word uses valid/ready. `snoop_ready` is low during reset and high at all other times, so the block never pushes back on a running bus. A word is consumed on each cycle where both `snoop_valid` and `snoop_ready` are high. The producer must hold the word's fields stable while `snoop_valid` is high and `snoop_ready` is low. The fields are don't-care while `snoop_valid` is low.

Top module: `vidshadow_snoop`

## Requirements
- R1: A captured cycle with `snoop_rnw` = 1 (read) never asserts `main_we` or `aux_we`.
- R2: A captured write raises a shadow write only if its address lies in 0x0400..0x0BFF or 0x2000..0x5FFF, bounds included. Writes to any other address raise none.
- R3: A captured write that is mirrored goes to the auxiliary port (`aux_we`) when `snoop_aux` = 1 in that word. It goes to the main port (`main_we`) when `snoop_aux` = 0. The two enables are never high together.
- R4: A shadow write carries the bus address unchanged, with only bits 7:0 of `snoop_data` as write data. It appears on the cycle after the handshake and lasts one cycle.
- R5: A captured write with `snoop_romsel` = 1 stores `snoop_data[7:0]` into mailbox entry `snoop_addr[4:0]`. It can be read on `cfg_rdata` from the cycle after the handshake.
- R6: A captured write with `snoop_romsel` = 1 and `snoop_addr[7:0]` = 0xFF pulses `cfg_done` high for exactly one cycle, on the cycle after the handshake. Nothing else raises `cfg_done`.
- R7: With `snoop_romsel` = 0, or for a read, the mailbox is left unchanged.
- R8: `snoop_ready` is 0 while `rst_n` is low and 1 otherwise. No cycle is consumed, and no write or pulse is issued, unless `snoop_valid` and `snoop_ready` are both high.
- R9: After reset, every mailbox entry reads 0 and all write enables and `cfg_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snoop_valid | input | 1 | Captured bus word present |
| snoop_ready | output | 1 | Block can take a word (high out of reset) |
| snoop_addr | input | 16 | Host bus address |
| snoop_data | input | 16 | Captured data field; bits 7:0 are the bus byte |
| snoop_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| snoop_aux | input | 1 | Bank-steering flag for this word |
| snoop_romsel | input | 1 | Card slot-ROM select for this word |
| main_we | output | 1 | Main shadow bank write enable |
| main_addr | output | 16 | Main shadow bank write address |
| main_wdata | output | 8 | Main shadow bank write data |
| aux_we | output | 1 | Auxiliary shadow bank write enable |
| aux_addr | output | 16 | Auxiliary shadow bank write address |
| aux_wdata | output | 8 | Auxiliary shadow bank write data |
| cfg_done | output | 1 | One-cycle mailbox completion pulse |
| cfg_raddr | input | 5 | Mailbox read index |
| cfg_rdata | output | 8 | Mailbox read data |

## Verification
The bench probes the exact edges of both windows: 0x03FF, 0x0400, 0x0BFF, 0x0C00, 0x1FFF, 0x2000, 0x5FFF and 0x6000. An off-by-one comparison would show up as a shadow write that should not happen, or as one that is missing. It sends reads that fall inside the windows and reads that hit address byte 0xFF with the select active. A decoder that ignored `snoop_rnw` would then shadow a read or fire `cfg_done` by mistake. It toggles `snoop_aux` from one word to the next, which exposes a flag that is sampled late or steers to the wrong bank. It also drives data with nonzero upper bits, which catches truncation taken from the wrong end. Mailbox writes sent with the select off, and idle cycles whose fields look like valid writes, confirm that nothing changes when no handshake happens.

// File: rtl/vidshadow_pkg.sv
package vidshadow_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam logic [ADDR_W-1:0] TXT_LO = 16'h0400;
  localparam logic [ADDR_W-1:0] TXT_HI = 16'h0BFF;
  localparam logic [ADDR_W-1:0] GFX_LO = 16'h2000;
  localparam logic [ADDR_W-1:0] GFX_HI = 16'h5FFF;

  typedef enum logic [1:0] {
    BANK_NONE = 2'd0,
    BANK_MAIN = 2'd1,
    BANK_AUX  = 2'd2
  } bank_e;
endpackage

// File: rtl/vs_window_decode.sv
module vs_window_decode
  import vidshadow_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic              in_window
);
  logic in_txt, in_gfx;
  always_comb begin
    in_txt    = (addr >= TXT_LO) && (addr <= TXT_HI);
    in_gfx    = (addr >= GFX_LO) && (addr <= GFX_HI);
    in_window = in_txt || in_gfx;
  end
endmodule

// File: rtl/vs_bank_steer.sv
module vs_bank_steer
  import vidshadow_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          is_write,
  input  logic          in_window,
  input  logic          aux_flag,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic [1:0]    we,
  output logic [AW-1:0] waddr [2],
  output logic [DW-1:0] wdata [2]
);
  bank_e target;
  always_comb begin
    target = BANK_NONE;
    if (fire && is_write && in_window)
      target = aux_flag ? BANK_AUX : BANK_MAIN;
  end

  for (genvar b = 0; b < 2; b++) begin : g_port
    localparam bank_e MY_BANK = (b == 0) ? BANK_MAIN : BANK_AUX;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        we[b]    <= 1'b0;
        waddr[b] <= '0;
        wdata[b] <= '0;
      end else begin
        we[b] <= (target == MY_BANK);
        if (target == MY_BANK) begin
          waddr[b] <= addr;
          wdata[b] <= data;
        end
      end
    end
  end

  // R1
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !is_write) |=> (we == 2'b00));
  // R3
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(we) <= 1);
  // R2
  window_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_window) |=> (we == 2'b00));
endmodule

// File: rtl/vs_cfg_mailbox.sv
module vs_cfg_mailbox #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 16,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          is_write,
  input  logic          romsel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          done
);
  logic [DW-1:0] slots [DEPTH];
  logic          store, last;

  always_comb begin
    store = fire && is_write && romsel;
    last  = store && (addr[7:0] == 8'hFF);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slots[i] <= '0;
      else if (store && (addr[IW-1:0] == IW'(i)))
        slots[i] <= data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= last;
  end

  assign rdata = slots[raddr];

  // R6
  done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_write && romsel && addr[7:0] == 8'hFF) |=> done);
  // R6
  done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire || !is_write || !romsel) |=> !done);
  // R7
  mailbox_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !romsel && raddr == addr[IW-1:0]) |=> $stable(rdata) || $changed(raddr));
endmodule

// File: rtl/vidshadow_snoop.sv
module vidshadow_snoop
  import vidshadow_pkg::*;
#(
  parameter int unsigned BUS_DW    = 16,
  parameter int unsigned CFG_DEPTH = 32,
  localparam int unsigned CFG_IW   = $clog2(CFG_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                snoop_valid,
  output logic                snoop_ready,
  input  logic [ADDR_W-1:0]   snoop_addr,
  input  logic [BUS_DW-1:0]   snoop_data,
  input  logic                snoop_rnw,
  input  logic                snoop_aux,
  input  logic                snoop_romsel,
  output logic                main_we,
  output logic [ADDR_W-1:0]   main_addr,
  output logic [BYTE_W-1:0]   main_wdata,
  output logic                aux_we,
  output logic [ADDR_W-1:0]   aux_addr,
  output logic [BYTE_W-1:0]   aux_wdata,
  output logic                cfg_done,
  input  logic [CFG_IW-1:0]   cfg_raddr,
  output logic [BYTE_W-1:0]   cfg_rdata
);
  logic              fire, in_win;
  logic [BYTE_W-1:0] byte_in;
  logic [1:0]        we;
  logic [ADDR_W-1:0] waddr [2];
  logic [BYTE_W-1:0] wdata [2];

  always_ff @(posedge clk) begin
    if (!rst_n) snoop_ready <= 1'b0;
    else        snoop_ready <= 1'b1;
  end

  assign fire    = snoop_valid && snoop_ready;
  assign byte_in = snoop_data[BYTE_W-1:0];

  vs_window_decode u_dec (.addr(snoop_addr), .in_window(in_win));

  vs_bank_steer #(.AW(ADDR_W), .DW(BYTE_W)) u_steer (
    .clk(clk), .rst_n(rst_n), .fire(fire), .is_write(!snoop_rnw),
    .in_window(in_win), .aux_flag(snoop_aux), .addr(snoop_addr),
    .data(byte_in), .we(we), .waddr(waddr), .wdata(wdata)
  );

  vs_cfg_mailbox #(.DEPTH(CFG_DEPTH), .DW(BYTE_W), .AW(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .fire(fire), .is_write(!snoop_rnw),
    .romsel(snoop_romsel), .addr(snoop_addr), .data(byte_in),
    .raddr(cfg_raddr), .rdata(cfg_rdata), .done(cfg_done)
  );

  assign main_we    = we[0];
  assign main_addr  = waddr[0];
  assign main_wdata = wdata[0];
  assign aux_we     = we[1];
  assign aux_addr   = waddr[1];
  assign aux_wdata  = wdata[1];

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(snoop_valid && snoop_ready) |=> !main_we && !aux_we && !cfg_done);
  // R3
  aux_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_ready && snoop_aux) |=> !main_we);
  // R4
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_we |=> !main_we || $past(snoop_valid));
endmodule

// File: tb/vidshadow_snoop_bench.sv
module vidshadow_snoop_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snoop_valid = 1'b0;
  logic        snoop_ready;
  logic [15:0] snoop_addr = '0;
  logic [15:0] snoop_data = '0;
  logic        snoop_rnw = 1'b1;
  logic        snoop_aux = 1'b0;
  logic        snoop_romsel = 1'b0;
  logic        main_we, aux_we, cfg_done;
  logic [15:0] main_addr, aux_addr;
  logic [7:0]  main_wdata, aux_wdata, cfg_rdata;
  logic [4:0]  cfg_raddr = '0;

  int checks = 0;
  int fails  = 0;
  bit done_run = 0;

  typedef struct {
    int          bank;   // 0 none, 1 main, 2 aux
    logic [15:0] addr;
    logic [7:0]  data;
    bit          pulse;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  vidshadow_snoop u_vidshadow_snoop (
    .clk(clk), .rst_n(rst_n), .snoop_valid(snoop_valid), .snoop_ready(snoop_ready),
    .snoop_addr(snoop_addr), .snoop_data(snoop_data), .snoop_rnw(snoop_rnw),
    .snoop_aux(snoop_aux), .snoop_romsel(snoop_romsel),
    .main_we(main_we), .main_addr(main_addr), .main_wdata(main_wdata),
    .aux_we(aux_we), .aux_addr(aux_addr), .aux_wdata(aux_wdata),
    .cfg_done(cfg_done), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [15:0] a);
    return (a >= 16'h0400 && a < 16'h0C00) || (a >= 16'h2000 && a < 16'h6000);
  endfunction

  // Driver: one word per call, expectation pushed once the edge has taken it.
  task automatic send(input logic [15:0] a, input logic [15:0] d, input bit rnw,
                      input bit aux, input bit rom, input string req);
    exp_t e;
    snoop_valid = 1'b1; snoop_addr = a; snoop_data = d;
    snoop_rnw = rnw; snoop_aux = aux; snoop_romsel = rom;
    e.bank  = (!rnw && in_win(a)) ? (aux ? 2 : 1) : 0;
    e.addr  = a;
    e.data  = d[7:0];
    e.pulse = !rnw && rom && (a[7:0] == 8'hFF);
    e.req   = req;
    @(posedge clk);
    sb.push_back(e);
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  // Monitor: compares every cycle's write ports with the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(main_we == (e.bank == 1), e.req, "main_we", 16'(main_we), 16'(e.bank == 1));
        check(aux_we == (e.bank == 2), e.req, "aux_we", 16'(aux_we), 16'(e.bank == 2));
        if (e.bank == 1) begin
          check(main_addr == e.addr, e.req, "main_addr", main_addr, e.addr);
          check(main_wdata == e.data, e.req, "main_wdata", 16'(main_wdata), 16'(e.data));
        end
        if (e.bank == 2) begin
          check(aux_addr == e.addr, e.req, "aux_addr", aux_addr, e.addr);
          check(aux_wdata == e.data, e.req, "aux_wdata", 16'(aux_wdata), 16'(e.data));
        end
        check(cfg_done == e.pulse, e.req, "cfg_done", 16'(cfg_done), 16'(e.pulse));
      end else if (main_we || aux_we || cfg_done) begin
        check(1'b0, "R8", "spurious activity", {13'd0, main_we, aux_we, cfg_done}, 16'd0);
      end
    end
  end

  task automatic read_cfg(input logic [4:0] idx, input logic [7:0] exp, input string req);
    cfg_raddr = idx;
    #1;
    check(cfg_rdata == exp, req, "cfg_rdata", 16'(cfg_rdata), 16'(exp));
  endtask

  initial begin
    #200000;
    if (!done_run) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 / R9: reset state
    check(snoop_ready == 1'b0, "R8", "ready in reset", 16'(snoop_ready), 16'd0);
    check(!main_we && !aux_we && !cfg_done, "R9", "outputs in reset",
          {13'd0, main_we, aux_we, cfg_done}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(snoop_ready == 1'b1, "R8", "ready after reset", 16'(snoop_ready), 16'd1);
    for (int i = 0; i < 32; i += 7) read_cfg(5'(i), 8'h00, "R9");

    // R2 window edges, R4 truncation
    send(16'h03FF, 16'h1111, 0, 0, 0, "R2");
    send(16'h0400, 16'hAB12, 0, 0, 0, "R2");
    send(16'h0BFF, 16'hCD34, 0, 0, 0, "R2");
    send(16'h0C00, 16'h0056, 0, 0, 0, "R2");
    send(16'h1FFF, 16'h0078, 0, 0, 0, "R2");
    send(16'h2000, 16'hFF9A, 0, 0, 0, "R4");
    send(16'h5FFF, 16'h80BC, 0, 0, 0, "R4");
    send(16'h6000, 16'h00DE, 0, 0, 0, "R2");
    // R1 reads inside windows
    send(16'h0800, 16'h0042, 1, 0, 0, "R1");
    send(16'h3000, 16'h0042, 1, 1, 0, "R1");
    // R3 bank steering, flag toggling word to word
    send(16'h0450, 16'h0001, 0, 1, 0, "R3");
    send(16'h0450, 16'h0002, 0, 0, 0, "R3");
    send(16'h4ABC, 16'h0003, 0, 1, 0, "R3");
    send(16'h4ABC, 16'h0004, 0, 0, 0, "R3");

    // R5 mailbox fill
    send(16'hC0A3, 16'h5A77, 0, 0, 1, "R5");
    send(16'hC010, 16'h0033, 0, 0, 1, "R5");
    read_cfg(5'd3, 8'h77, "R5");
    read_cfg(5'd16, 8'h33, "R5");
    // R7 select off / read leave mailbox alone
    send(16'hC003, 16'h0099, 0, 0, 0, "R7");
    send(16'hC010, 16'h0088, 1, 0, 1, "R7");
    read_cfg(5'd3, 8'h77, "R7");
    read_cfg(5'd16, 8'h33, "R7");
    // R6 completion pulse
    send(16'hC0FF, 16'h00EE, 0, 0, 1, "R6");
    read_cfg(5'd31, 8'hEE, "R5");
    send(16'hC0FF, 16'h0011, 0, 0, 0, "R6");
    send(16'hC0FF, 16'h0011, 1, 0, 1, "R6");
    send(16'h05FF, 16'h0022, 0, 1, 1, "R6");
    read_cfg(5'd31, 8'h22, "R5");

    // R8: idle cycles with write-like fields do nothing
    snoop_addr = 16'h0500; snoop_rnw = 1'b0; snoop_romsel = 1'b1; snoop_data = 16'h00AA;
    cfg_raddr = 5'd0;
    repeat (4) @(negedge clk);
    check(cfg_rdata == 8'h00, "R8", "mailbox after idle", 16'(cfg_rdata), 16'h00);

    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R4", "scoreboard drained", 16'(sb.size()), 16'd0);
    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule